// File: doc/BRIEF.md
# Free-running 64-bit timer with periodic compare

This block keeps a 64-bit up-counter that advances by one on every clock while its run bit is set, and watches it with a single 64-bit compare channel. When the counter reaches the compare value, a sticky pending flag is raised. If the interrupt enable bit is also set, that flag drives the interrupt line. Software sees the counter, the compare value and the other controls as 32-bit words on a simple register bus. Writes take effect on the next clock edge. Reads return data in the same cycle.

With auto-increment off the channel is a one-shot: it fires once and then leaves the compare value alone. With auto-increment on, every match adds a programmable step to the compare value. One comparator then gives an endless train of events, one step apart. Because the counter is wider than the bus, software reads it as upper word, lower word, upper word again and retries on a mismatch. The upper word must therefore carry correctly out of the lower one. Software may also load either counter word directly.

Top module: `gct_timer`

## Requirements
- R1: After reset, every register reads zero, the counter is stopped and holds its value, and `irq` is low.
- R2: The counter's lower word reads at 0x100 and its upper word at 0x104. While control bit 8 (run) is set, the counter grows by exactly one per clock. While bit 8 is clear, it holds.
- R3: The counter is a single 64-bit quantity: when the lower word passes 0xFFFFFFFF, the upper word increases by one on the same clock.
- R4: A bus write to 0x100 or 0x104 loads that word of the counter at the next edge. On that edge the counter does not increment.
- R5: Several registers read back what was written to them: the compare lower word (0x200), the compare upper word (0x204) and the step (0x208). The control register at 0x240 reads back only bits 8, 1 and 0.
- R6: With control bit 0 (compare enable) set, a cycle in which the counter equals the compare value sets the pending flag at the next clock edge.
- R7: With control bit 1 (auto-increment) also set, each match adds the step, zero-extended to 64 bits with carry, to the compare value on the same edge. The next event therefore arrives exactly one step of counts later.
- R8: With auto-increment clear, a match leaves the compare value unchanged, and no further event occurs while the counter moves away from it.
- R9: The pending flag reads at bit 0 of 0x244 and stays set until software writes 1 to that bit. Writing 0 there has no effect.
- R10: Bit 0 of 0x248 enables the interrupt. `irq` is high exactly when the pending flag and this enable are both set, and the pending flag is visible even when the enable is clear.
- R11: Clearing compare enable stops new matches but leaves an already pending flag set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, same cycle |
| irq | output | 1 | Compare interrupt, pending AND enable |

## Verification
A wrong carry between the counter words shows up as an upper word that is off by one. This is visible on the first read after the lower word wraps. A faulty compare path shows up on `irq` one edge after the counter reaches the compare value: the line either rises a cycle early or late, or not at all. A wrong auto-increment sum moves the second event away from exactly one step later, and the compare words read back wrong directly after the first match. A pending flag that clears itself or ignores the clear write shows on `irq` and on the status read within one cycle.

// File: rtl/gct_pkg.sv
// Package gct_pkg
// Shared register offsets and control bit positions for the compare timer.
// Assumes a byte-addressed bus with a 4-byte stride between words.
package gct_pkg;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] A_CNT_LO = 12'h100;
    localparam logic [ADDR_W-1:0] A_CMP_LO = 12'h200;
    localparam logic [ADDR_W-1:0] A_STEP   = 12'h208;
    localparam logic [ADDR_W-1:0] A_CTRL   = 12'h240;
    localparam logic [ADDR_W-1:0] A_STAT   = 12'h244;
    localparam logic [ADDR_W-1:0] A_IEN    = 12'h248;

    localparam int B_CMPEN = 0;
    localparam int B_AUTO  = 1;
    localparam int B_RUN   = 8;
endpackage

// File: rtl/gct_counter.sv
// Module gct_counter
// Multi-word free-running up-counter. Any word may be loaded from the bus.
// A load freezes the other words for that cycle, so software sees exactly
// the value it wrote. Assumes at most one word write per cycle.
module gct_counter #(
    parameter  int BUS_W  = 32,
    parameter  int NWORDS = 2,
    localparam int CNT_W  = BUS_W * NWORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [NWORDS-1:0] wr_word,
    input  logic [BUS_W-1:0]  wdata,
    output logic [CNT_W-1:0]  cnt
);
    logic [CNT_W-1:0] cnt_inc;
    logic             any_wr;

    // Full-width increment so carries ripple across word boundaries.
    assign cnt_inc = cnt + CNT_W'(1);
    assign any_wr  = |wr_word;

    // Counter state: bus load first, then increment while running.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (any_wr) begin
            for (int w = 0; w < NWORDS; w++) begin
                if (wr_word[w]) cnt[w*BUS_W +: BUS_W] <= wdata;
            end
        end else if (run) begin
            cnt <= cnt_inc;
        end
    end

    p_count_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !any_wr) |=> cnt == $past(cnt) + CNT_W'(1));
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !any_wr) |=> $stable(cnt));
    p_load_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_word[0] |=> cnt[BUS_W-1:0] == $past(wdata));
endmodule

// File: rtl/gct_compare.sv
// Module gct_compare
// One 64-bit compare channel. It holds the compare value and the step, and
// advances the compare value by the step on a match when auto-increment is
// on. It also holds the sticky pending flag. Assumes cnt comes straight from
// the counter register.
module gct_compare #(
    parameter  int BUS_W  = 32,
    parameter  int NWORDS = 2,
    localparam int CNT_W  = BUS_W * NWORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              cmp_en,
    input  logic              auto_en,
    input  logic [NWORDS-1:0] wr_word,
    input  logic              wr_step,
    input  logic              clr_pend,
    input  logic [BUS_W-1:0]  wdata,
    output logic [CNT_W-1:0]  cmp,
    output logic [BUS_W-1:0]  step,
    output logic              pending
);
    logic match;

    // Equality match, gated by compare enable.
    assign match = cmp_en && (cnt == cmp);

    // Compare value: a bus load wins over the auto-increment advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp <= '0;
        end else if (|wr_word) begin
            for (int w = 0; w < NWORDS; w++) begin
                if (wr_word[w]) cmp[w*BUS_W +: BUS_W] <= wdata;
            end
        end else if (match && auto_en) begin
            cmp <= cmp + CNT_W'(step);
        end
    end

    // Step register, written only from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)       step <= '0;
        else if (wr_step) step <= wdata;
    end

    // Sticky pending flag: a match sets it, a software clear resets it.
    always_ff @(posedge clk) begin
        if (!rst_n)        pending <= 1'b0;
        else if (match)    pending <= 1'b1;
        else if (clr_pend) pending <= 1'b0;
    end

    p_match_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        match |=> pending);
    p_autoinc_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (match && auto_en && !(|wr_word)) |=> cmp == $past(cmp) + CNT_W'($past(step)));
    p_oneshot_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!auto_en && !(|wr_word)) |=> $stable(cmp));
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !clr_pend) |=> pending);
    p_no_new_match_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmp_en && !pending) |=> !pending);
endmodule

// File: rtl/gct_timer.sv
// Module gct_timer
// Top level: register decode and read mux around the counter and the compare
// channel. Control, interrupt enable and the interrupt gate live here.
// Assumes single-cycle write strobes and combinational reads.
module gct_timer #(
    parameter  int BUS_W  = 32,
    localparam int NWORDS = 2,
    localparam int CNT_W  = BUS_W * NWORDS
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      bus_wr,
    input  logic [gct_pkg::ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]          bus_wdata,
    output logic [BUS_W-1:0]          bus_rdata,
    output logic                      irq
);
    import gct_pkg::*;

    logic              run_q, auto_q, cmpen_q, ien_q;
    logic [NWORDS-1:0] cnt_wr, cmp_wr;
    logic [CNT_W-1:0]  cnt, cmp;
    logic [BUS_W-1:0]  step;
    logic              pending;
    logic              clr_pend;

    // Per-word write decode for the counter and compare words.
    for (genvar w = 0; w < NWORDS; w++) begin : g_word_dec
        assign cnt_wr[w] = bus_wr && (bus_addr == A_CNT_LO + ADDR_W'(4 * w));
        assign cmp_wr[w] = bus_wr && (bus_addr == A_CMP_LO + ADDR_W'(4 * w));
    end

    assign clr_pend = bus_wr && (bus_addr == A_STAT) && bus_wdata[0];

    // Control and interrupt-enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            auto_q  <= 1'b0;
            cmpen_q <= 1'b0;
            ien_q   <= 1'b0;
        end else if (bus_wr) begin
            if (bus_addr == A_CTRL) begin
                run_q   <= bus_wdata[B_RUN];
                auto_q  <= bus_wdata[B_AUTO];
                cmpen_q <= bus_wdata[B_CMPEN];
            end
            if (bus_addr == A_IEN) ien_q <= bus_wdata[0];
        end
    end

    gct_counter #(.BUS_W(BUS_W), .NWORDS(NWORDS)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run_q),
        .wr_word (cnt_wr),
        .wdata   (bus_wdata),
        .cnt     (cnt)
    );

    gct_compare #(.BUS_W(BUS_W), .NWORDS(NWORDS)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .cnt      (cnt),
        .cmp_en   (cmpen_q),
        .auto_en  (auto_q),
        .wr_word  (cmp_wr),
        .wr_step  (bus_wr && (bus_addr == A_STEP)),
        .clr_pend (clr_pend),
        .wdata    (bus_wdata),
        .cmp      (cmp),
        .step     (step),
        .pending  (pending)
    );

    // Interrupt line: pending flag gated by the enable bit.
    assign irq = pending && ien_q;

    // Read mux: word-indexed counter and compare values, then the rest.
    always_comb begin
        bus_rdata = '0;
        for (int w = 0; w < NWORDS; w++) begin
            if (bus_addr == A_CNT_LO + ADDR_W'(4 * w)) bus_rdata = cnt[w*BUS_W +: BUS_W];
            if (bus_addr == A_CMP_LO + ADDR_W'(4 * w)) bus_rdata = cmp[w*BUS_W +: BUS_W];
        end
        if (bus_addr == A_STEP) bus_rdata = step;
        if (bus_addr == A_CTRL) begin
            bus_rdata[B_RUN]   = run_q;
            bus_rdata[B_AUTO]  = auto_q;
            bus_rdata[B_CMPEN] = cmpen_q;
        end
        if (bus_addr == A_STAT) bus_rdata[0] = pending;
        if (bus_addr == A_IEN)  bus_rdata[0] = ien_q;
    end

    p_reset_quiet_r1: assert property (@(posedge clk)
        !rst_n |=> (!irq && !run_q && !cmpen_q));
    p_irq_needs_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_pend && !cmpen_q) |=> !irq);
endmodule

// File: tb/sim_gct_timer.sv
module sim_gct_timer;
    localparam logic [11:0] CNT_LO = 12'h100, CNT_HI = 12'h104;
    localparam logic [11:0] CMP_LO = 12'h200, CMP_HI = 12'h204, STEP = 12'h208;
    localparam logic [11:0] CTRL = 12'h240, STAT = 12'h244, IEN = 12'h248;

    logic        clk, rst_n, bus_wr, irq;
    logic [11:0] bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    int          cyc = 0;
    int          checks = 0, fails = 0;
    bit          done = 0;

    gct_timer u0 (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    initial clk = 0;
    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        bus_addr = a; #1; d = bus_rdata;
    endtask

    task automatic rd64(input logic [11:0] a, output logic [63:0] d);
        logic [31:0] lo, hi;
        rd(a + 12'h4, hi); rd(a, lo); d = {hi, lo};
    endtask

    task automatic wait_to(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    function automatic logic [63:0] cmp_after(logic [63:0] c0, logic [31:0] s, int n);
        return c0 + 64'(s) * 64'(n);
    endfunction

    initial begin
        #2_000_000;
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic [63:0] v64, cnt0, cmp0;
        int t0, m, d, s;
        void'($urandom(32'd20250917));
        rst_n = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1: reset state
        rd64(CNT_LO, v64); chk("R1 counter", v64, 64'd0);
        rd64(CMP_LO, v64); chk("R1 compare", v64, 64'd0);
        rd(CTRL, v); chk("R1 ctrl", 64'(v), 0);
        rd(STAT, v); chk("R1 status", 64'(v), 0);
        chk("R1 irq", 64'(irq), 0);
        repeat (5) @(negedge clk);
        rd64(CNT_LO, v64); chk("R1 R2 stopped counter holds", v64, 64'd0);

        // R5: control read-back masks unused bits
        wr(CTRL, 32'hFFFF_FFFF); rd(CTRL, v); chk("R5 ctrl mask", 64'(v), 64'h103);
        wr(CTRL, 0); wr(STEP, 32'hA5A5_1234); rd(STEP, v); chk("R5 step", 64'(v), 64'hA5A5_1234);
        wr(CMP_LO, 32'h1357_9BDF); wr(CMP_HI, 32'h2468_ACE0);
        rd64(CMP_LO, v64); chk("R5 compare", v64, 64'h2468_ACE0_1357_9BDF);

        // R4 load, R3 carry, R2 rate
        wr(CNT_LO, 32'hFFFF_FFFD); wr(CNT_HI, 32'd7);
        rd64(CNT_LO, v64); chk("R4 load", v64, 64'h7_FFFF_FFFD);
        wr(CTRL, 32'h100); t0 = cyc;
        wait_to(t0 + 4);
        rd64(CNT_LO, v64); chk("R3 carry into upper", v64, 64'h8_0000_0001);
        wait_to(t0 + 10);
        rd64(CNT_LO, v64); chk("R2 one per clock", v64, 64'h8_0000_0007);
        wr(CNT_LO, 32'h50); t0 = cyc;
        rd64(CNT_LO, v64); chk("R4 write beats increment", v64, 64'h8_0000_0050);
        wait_to(t0 + 2);
        rd64(CNT_LO, v64); chk("R4 R2 resumes", v64, 64'h8_0000_0052);

        // R6, R8: one-shot
        wr(CTRL, 0); wr(STAT, 1);
        wr(CNT_LO, 100); wr(CNT_HI, 0); wr(CMP_LO, 110); wr(CMP_HI, 0);
        wr(STEP, 7); wr(IEN, 1); wr(CTRL, 32'h101); t0 = cyc;
        m = t0 + 11;
        wait_to(m - 1); chk("R6 no irq before match", 64'(irq), 0);
        wait_to(m);     chk("R6 irq on match", 64'(irq), 1);
        rd64(CMP_LO, v64); chk("R8 compare unchanged", v64, 64'd110);
        wr(STAT, 1); chk("R9 clear", 64'(irq), 0);
        wait_to(m + 60); chk("R8 no second event", 64'(irq), 0);

        // R7, R9, R10, R11: periodic, directed
        wr(CTRL, 0); wr(STAT, 1);
        wr(CNT_LO, 0); wr(CMP_LO, 20); wr(STEP, 15); wr(CTRL, 32'h103); t0 = cyc;
        m = t0 + 21;
        wait_to(m); chk("R6 periodic first", 64'(irq), 1);
        rd(CMP_LO, v); chk("R7 compare advanced", 64'(v), 35);
        wr(STAT, 0); chk("R9 write 0 ignored", 64'(irq), 1);
        wr(IEN, 0); chk("R10 masked irq", 64'(irq), 0);
        rd(STAT, v); chk("R10 pending visible", 64'(v), 1);
        wr(IEN, 1); chk("R10 unmasked irq", 64'(irq), 1);
        wr(CTRL, 32'h100); chk("R11 pending kept", 64'(irq), 1);
        wr(STAT, 1);
        wait_to(m + 60); chk("R11 no new match", 64'(irq), 0);
        rd(STAT, v); chk("R11 status clear", 64'(v), 0);

        // R3, R6, R7, R9: random periodic runs
        for (int it = 0; it < 10; it++) begin
            cnt0[63:32] = $urandom;
            cnt0[31:0]  = (it % 2 == 1) ? 32'hFFFF_FFE0 + ($urandom % 16) : $urandom;
            d = 5 + int'($urandom % 30);
            s = 3 + int'($urandom % 20);
            cmp0 = cnt0 + 64'(d);
            wr(CTRL, 0); wr(STAT, 1);
            wr(CNT_LO, cnt0[31:0]); wr(CNT_HI, cnt0[63:32]);
            wr(CMP_LO, cmp0[31:0]); wr(CMP_HI, cmp0[63:32]);
            wr(STEP, 32'(s)); wr(IEN, 1); wr(CTRL, 32'h103); t0 = cyc;
            m = t0 + d + 1;
            wait_to(m - 1); chk("R6 random early", 64'(irq), 0);
            wait_to(m);     chk("R6 random match", 64'(irq), 1);
            rd64(CNT_LO, v64); chk("R3 random count", v64, cnt0 + 64'(d + 1));
            wr(STAT, 1);
            rd64(CMP_LO, v64); chk("R7 random compare", v64, cmp_after(cmp0, 32'(s), 1));
            wait_to(m + s - 1); chk("R9 random cleared", 64'(irq), 0);
            wait_to(m + s);     chk("R7 random period", 64'(irq), 1);
            rd64(CMP_LO, v64); chk("R7 random second", v64, cmp_after(cmp0, 32'(s), 2));
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule